// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Path

This block supplies the two ALU operands and the store data of a five-stage integer pipeline. On each rising clock edge it captures the decoded source register indices, their register-file read values, the immediate and the immediate-select flag. Together these form the decode-to-execute pipeline register. In the execute cycle that follows, a forwarding controller compares each captured source index with the destination index and write enable of the two later stages, memory and write-back. It then steers a 4:1 operand multiplexer for each source.

The source for operand B is the memory-stage ALU result, the write-back result or the captured register value. That forwarded value goes out unchanged as the store data. The same value also feeds a 2:1 multiplexer, which can replace it with the sign-extended immediate. The ALU is not part of the block. Its two inputs are the outputs `op_a_o` and `op_b_o`.

Top module: `exec_operand_fwd`

## Requirements
- R1: While `rst_ni` is low, the captured indices, values, immediate and select flag are zero. So `op_a_o`, `op_b_o` and `st_data_o` are zero, and both select codes are 00, whatever the forwarding inputs hold.
- R2: The decode inputs are sampled only on a rising edge of `clk_i`. A change between edges leaves every output unchanged until the next edge.
- R3: If `exm_wr_en_i` is 1, `exm_dst_i` equals the captured A index and that index is not 0, then `sel_a_o` is 10 and `op_a_o` equals `exm_alu_res_i` in the same cycle.
- R4: If the R3 condition fails for operand A, `mwb_wr_en_i` is 1, `mwb_dst_i` equals the captured A index and that index is not 0, then `sel_a_o` is 01 and `op_a_o` equals `wb_res_i`.
- R5: When both later stages match the same source index, the memory stage (code 10) wins over write-back.
- R6: A source index of 0 never forwards. Its select code is 00 and the operand is the captured register value.
- R7: A stage whose write enable is 0 never forwards, even when its destination matches.
- R8: Operand B is selected independently of operand A. It uses the captured B index and the same codes and priority as R3 to R7. Code 00 means the captured register value.
- R9: `st_data_o` is always the forwarded operand-B value, whatever the value of `alu_src_i`.
- R10: With the captured `alu_src_i` at 1, `op_b_o` is the immediate sign-extended from bit `IMM_W-1`. With it at 0, `op_b_o` equals `st_data_o`.
- R11: Neither select output ever takes the code 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dec_a_idx_i | input | REG_AW | Decoded index of source A (rs) |
| dec_b_idx_i | input | REG_AW | Decoded index of source B (rt) |
| dec_a_val_i | input | DATA_W | Register-file value of source A |
| dec_b_val_i | input | DATA_W | Register-file value of source B |
| dec_imm_i | input | IMM_W | Raw immediate field |
| alu_src_i | input | 1 | 1 selects the immediate for operand B |
| exm_wr_en_i | input | 1 | Memory-stage register write enable |
| exm_dst_i | input | REG_AW | Memory-stage destination index |
| exm_alu_res_i | input | DATA_W | Memory-stage ALU result |
| mwb_wr_en_i | input | 1 | Write-back-stage register write enable |
| mwb_dst_i | input | REG_AW | Write-back-stage destination index |
| wb_res_i | input | DATA_W | Write-back result |
| sel_a_o | output | 2 | Operand A source code |
| sel_b_o | output | 2 | Operand B source code |
| op_a_o | output | DATA_W | ALU operand A |
| op_b_o | output | DATA_W | ALU operand B |
| st_data_o | output | DATA_W | Store data (forwarded B) |

## Verification
Decode-side fields reach the outputs one rising edge after they are presented. The forwarding inputs from the two later stages act combinationally in the same cycle. The bench therefore drives every input on the falling edge and samples all outputs 2 ns after the following rising edge. At that point the captured fields and the live forwarding inputs of the current cycle are both settled. For the capture rule it also samples just after a mid-cycle change to confirm that nothing moved before the edge.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_EXM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/idex_operand_reg.sv
module idex_operand_reg #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5,
  parameter int IMM_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] a_idx_i,
  input  logic [REG_AW-1:0] b_idx_i,
  input  logic [DATA_W-1:0] a_val_i,
  input  logic [DATA_W-1:0] b_val_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              alu_src_i,
  output logic [REG_AW-1:0] a_idx_o,
  output logic [REG_AW-1:0] b_idx_o,
  output logic [DATA_W-1:0] a_val_o,
  output logic [DATA_W-1:0] b_val_o,
  output logic [IMM_W-1:0]  imm_o,
  output logic              alu_src_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_idx_o   <= '0;
      b_idx_o   <= '0;
      a_val_o   <= '0;
      b_val_o   <= '0;
      imm_o     <= '0;
      alu_src_o <= 1'b0;
    end else begin
      a_idx_o   <= a_idx_i;
      b_idx_o   <= b_idx_i;
      a_val_o   <= a_val_i;
      b_val_o   <= b_val_i;
      imm_o     <= imm_i;
      alu_src_o <= alu_src_i;
    end
  end
endmodule

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_idx_i,
  input  logic              exm_wr_en_i,
  input  logic [REG_AW-1:0] exm_dst_i,
  input  logic              mwb_wr_en_i,
  input  logic [REG_AW-1:0] mwb_dst_i,
  output fwd_sel_e          sel_o
);
  logic src_live;
  logic hit_exm;
  logic hit_mwb;

  // index 0 is hardwired zero: never a forwarding target
  assign src_live = (src_idx_i != '0);
  assign hit_exm  = src_live && exm_wr_en_i && (exm_dst_i == src_idx_i);
  assign hit_mwb  = src_live && mwb_wr_en_i && (mwb_dst_i == src_idx_i);

  always_comb begin
    if (hit_exm)      sel_o = FWD_EXM;
    else if (hit_mwb) sel_o = FWD_WB;
    else              sel_o = FWD_RF;
  end
endmodule

// File: rtl/operand_mux4.sv
module operand_mux4
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwd_sel_e          sel_i,
  input  logic [DATA_W-1:0] rf_val_i,
  input  logic [DATA_W-1:0] wb_val_i,
  input  logic [DATA_W-1:0] exm_val_i,
  output logic [DATA_W-1:0] val_o
);
  always_comb begin
    case (sel_i)
      FWD_EXM: val_o = exm_val_i;
      FWD_WB:  val_o = wb_val_i;
      default: val_o = rf_val_i;
    endcase
  end
endmodule

// File: rtl/exec_operand_fwd.sv
module exec_operand_fwd
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5,
  parameter int IMM_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] dec_a_idx_i,
  input  logic [REG_AW-1:0] dec_b_idx_i,
  input  logic [DATA_W-1:0] dec_a_val_i,
  input  logic [DATA_W-1:0] dec_b_val_i,
  input  logic [IMM_W-1:0]  dec_imm_i,
  input  logic              alu_src_i,
  input  logic              exm_wr_en_i,
  input  logic [REG_AW-1:0] exm_dst_i,
  input  logic [DATA_W-1:0] exm_alu_res_i,
  input  logic              mwb_wr_en_i,
  input  logic [REG_AW-1:0] mwb_dst_i,
  input  logic [DATA_W-1:0] wb_res_i,
  output logic [1:0]        sel_a_o,
  output logic [1:0]        sel_b_o,
  output logic [DATA_W-1:0] op_a_o,
  output logic [DATA_W-1:0] op_b_o,
  output logic [DATA_W-1:0] st_data_o
);
  localparam int NUM_SRC = 2;
  localparam int EXT_W   = DATA_W - IMM_W;

  logic [REG_AW-1:0] a_idx_q, b_idx_q;
  logic [DATA_W-1:0] a_val_q, b_val_q;
  logic [IMM_W-1:0]  imm_q;
  logic              alu_src_q;

  idex_operand_reg #(
    .DATA_W(DATA_W), .REG_AW(REG_AW), .IMM_W(IMM_W)
  ) u_idex (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_idx_i   (dec_a_idx_i),
    .b_idx_i   (dec_b_idx_i),
    .a_val_i   (dec_a_val_i),
    .b_val_i   (dec_b_val_i),
    .imm_i     (dec_imm_i),
    .alu_src_i (alu_src_i),
    .a_idx_o   (a_idx_q),
    .b_idx_o   (b_idx_q),
    .a_val_o   (a_val_q),
    .b_val_o   (b_val_q),
    .imm_o     (imm_q),
    .alu_src_o (alu_src_q)
  );

  logic [NUM_SRC-1:0][REG_AW-1:0] src_idx;
  logic [NUM_SRC-1:0][DATA_W-1:0] src_val;
  logic [NUM_SRC-1:0][DATA_W-1:0] fwd_val;
  fwd_sel_e                       src_sel [NUM_SRC];

  assign src_idx[0] = a_idx_q;
  assign src_idx[1] = b_idx_q;
  assign src_val[0] = a_val_q;
  assign src_val[1] = b_val_q;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    fwd_ctrl #(.REG_AW(REG_AW)) u_ctrl (
      .src_idx_i   (src_idx[s]),
      .exm_wr_en_i (exm_wr_en_i),
      .exm_dst_i   (exm_dst_i),
      .mwb_wr_en_i (mwb_wr_en_i),
      .mwb_dst_i   (mwb_dst_i),
      .sel_o       (src_sel[s])
    );

    operand_mux4 #(.DATA_W(DATA_W)) u_mux (
      .sel_i     (src_sel[s]),
      .rf_val_i  (src_val[s]),
      .wb_val_i  (wb_res_i),
      .exm_val_i (exm_alu_res_i),
      .val_o     (fwd_val[s])
    );
  end

  logic [DATA_W-1:0] imm_ext;
  assign imm_ext = {{EXT_W{imm_q[IMM_W-1]}}, imm_q};

  assign sel_a_o   = src_sel[0];
  assign sel_b_o   = src_sel[1];
  assign op_a_o    = fwd_val[0];
  // store data taps operand B ahead of the immediate mux
  assign st_data_o = fwd_val[1];
  assign op_b_o    = alu_src_q ? imm_ext : fwd_val[1];
endmodule

// File: rtl/exec_operand_fwd_chk.sv
module exec_operand_fwd_chk #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              exm_wr_en_i,
  input logic [REG_AW-1:0] exm_dst_i,
  input logic [DATA_W-1:0] exm_alu_res_i,
  input logic              mwb_wr_en_i,
  input logic [REG_AW-1:0] mwb_dst_i,
  input logic [DATA_W-1:0] wb_res_i,
  input logic [REG_AW-1:0] a_idx_q,
  input logic [REG_AW-1:0] b_idx_q,
  input logic              alu_src_q,
  input logic [1:0]        sel_a_o,
  input logic [1:0]        sel_b_o,
  input logic [DATA_W-1:0] op_a_o,
  input logic [DATA_W-1:0] op_b_o,
  input logic [DATA_W-1:0] st_data_o
);
  a_r11_no_code3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_a_o != 2'b11) && (sel_b_o != 2'b11));

  a_r3_exm_fwd_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_a_o == 2'b10) |-> (op_a_o == exm_alu_res_i) && exm_wr_en_i &&
                           (exm_dst_i == a_idx_q) && (a_idx_q != '0));

  a_r4_wb_fwd_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_a_o == 2'b01) |-> (op_a_o == wb_res_i) && mwb_wr_en_i &&
                           (mwb_dst_i == a_idx_q) && (a_idx_q != '0));

  a_r5_exm_priority_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exm_wr_en_i && (exm_dst_i == a_idx_q) && (a_idx_q != '0)) |-> (sel_a_o == 2'b10));

  a_r6_zero_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((a_idx_q == '0) |-> (sel_a_o == 2'b00)) and ((b_idx_q == '0) |-> (sel_b_o == 2'b00)));

  a_r8_exm_fwd_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_b_o == 2'b10) |-> (st_data_o == exm_alu_res_i) && exm_wr_en_i &&
                           (exm_dst_i == b_idx_q));

  a_r10_reg_path_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alu_src_q |-> (op_b_o == st_data_o));
endmodule

bind exec_operand_fwd exec_operand_fwd_chk #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .exm_wr_en_i   (exm_wr_en_i),
  .exm_dst_i     (exm_dst_i),
  .exm_alu_res_i (exm_alu_res_i),
  .mwb_wr_en_i   (mwb_wr_en_i),
  .mwb_dst_i     (mwb_dst_i),
  .wb_res_i      (wb_res_i),
  .a_idx_q       (a_idx_q),
  .b_idx_q       (b_idx_q),
  .alu_src_q     (alu_src_q),
  .sel_a_o       (sel_a_o),
  .sel_b_o       (sel_b_o),
  .op_a_o        (op_a_o),
  .op_b_o        (op_b_o),
  .st_data_o     (st_data_o)
);

// File: tb/exec_operand_fwd_test.sv
module exec_operand_fwd_test;
  localparam int DW = 32;
  localparam int AW = 5;
  localparam int IW = 16;
  localparam int NV = 11;

  typedef struct packed {
    logic [AW-1:0] a_idx;
    logic [AW-1:0] b_idx;
    logic [IW-1:0] imm;
    logic          alu_src;
    logic          ew;
    logic [AW-1:0] ed;
    logic          mw;
    logic [AW-1:0] md;
    logic [1:0]    sa;
    logic [1:0]    sb;
  } vec_t;

  // a_idx b_idx imm alu_src exm_we exm_dst mwb_we mwb_dst exp_sel_a exp_sel_b
  localparam vec_t VECS [NV] = '{
    '{5'd3,  5'd4,  16'h0000, 1'b0, 1'b0, 5'd0,  1'b0, 5'd0,  2'b00, 2'b00},
    '{5'd3,  5'd4,  16'h0000, 1'b0, 1'b1, 5'd3,  1'b0, 5'd0,  2'b10, 2'b00},
    '{5'd3,  5'd4,  16'h0000, 1'b0, 1'b0, 5'd3,  1'b1, 5'd4,  2'b00, 2'b01},
    '{5'd3,  5'd3,  16'h0000, 1'b0, 1'b1, 5'd3,  1'b1, 5'd3,  2'b10, 2'b10},
    '{5'd3,  5'd5,  16'h0000, 1'b0, 1'b1, 5'd5,  1'b1, 5'd3,  2'b01, 2'b10},
    '{5'd3,  5'd3,  16'h0000, 1'b0, 1'b0, 5'd3,  1'b0, 5'd3,  2'b00, 2'b00},
    '{5'd0,  5'd0,  16'h0000, 1'b0, 1'b1, 5'd0,  1'b1, 5'd0,  2'b00, 2'b00},
    '{5'd6,  5'd4,  16'h8004, 1'b1, 1'b0, 5'd0,  1'b1, 5'd4,  2'b00, 2'b01},
    '{5'd6,  5'd4,  16'h0123, 1'b1, 1'b1, 5'd9,  1'b1, 5'd8,  2'b00, 2'b00},
    '{5'd7,  5'd7,  16'hfff0, 1'b1, 1'b1, 5'd7,  1'b1, 5'd7,  2'b10, 2'b10},
    '{5'd31, 5'd31, 16'h0000, 1'b0, 1'b1, 5'd30, 1'b1, 5'd31, 2'b01, 2'b01}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] dec_a_idx_i = '0, dec_b_idx_i = '0;
  logic [DW-1:0] dec_a_val_i = '0, dec_b_val_i = '0;
  logic [IW-1:0] dec_imm_i = '0;
  logic          alu_src_i = 1'b0;
  logic          exm_wr_en_i = 1'b0, mwb_wr_en_i = 1'b0;
  logic [AW-1:0] exm_dst_i = '0, mwb_dst_i = '0;
  logic [DW-1:0] exm_alu_res_i = '0, wb_res_i = '0;
  logic [1:0]    sel_a_o, sel_b_o;
  logic [DW-1:0] op_a_o, op_b_o, st_data_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk_i = ~clk_i;

  exec_operand_fwd #(.DATA_W(DW), .REG_AW(AW), .IMM_W(IW)) uut (.*);

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pick(input logic [1:0] s, input logic [DW-1:0] rf,
                                         input logic [DW-1:0] wb, input logic [DW-1:0] ex);
    return (s == 2'b10) ? ex : (s == 2'b01) ? wb : rf;
  endfunction

  initial begin
    // R1: reset state, forwarding inputs active and aimed at index 0
    exm_wr_en_i = 1'b1; mwb_wr_en_i = 1'b1;
    exm_alu_res_i = 32'hdead0001; wb_res_i = 32'hdead0002;
    dec_a_idx_i = 5'd2; dec_a_val_i = 32'h11112222; dec_b_idx_i = 5'd2;
    @(posedge clk_i); #2;
    chk("R1 op_a", op_a_o, '0);
    chk("R1 op_b", op_b_o, '0);
    chk("R1 st_data", st_data_o, '0);
    chk("R1 sel_a", {30'd0, sel_a_o}, '0);
    chk("R1 sel_b", {30'd0, sel_b_o}, '0);
    @(negedge clk_i); rst_ni = 1'b1;

    // table walk: R3 R4 R5 R6 R7 R8 R9 R10 R11
    for (int i = 0; i < NV; i++) begin
      logic [DW-1:0] av, bv, ex, wb, fb;
      av = 32'ha0000000 + i; bv = 32'hb0000000 + i;
      ex = 32'hc0000000 + i; wb = 32'hd0000000 + i;
      @(negedge clk_i);
      dec_a_idx_i = VECS[i].a_idx; dec_b_idx_i = VECS[i].b_idx;
      dec_a_val_i = av; dec_b_val_i = bv;
      dec_imm_i = VECS[i].imm; alu_src_i = VECS[i].alu_src;
      exm_wr_en_i = VECS[i].ew; exm_dst_i = VECS[i].ed; exm_alu_res_i = ex;
      mwb_wr_en_i = VECS[i].mw; mwb_dst_i = VECS[i].md; wb_res_i = wb;
      @(posedge clk_i); #2;
      fb = pick(VECS[i].sb, bv, wb, ex);
      chk($sformatf("R3 R4 R5 R6 R7 sel_a vec %0d", i), {30'd0, sel_a_o}, {30'd0, VECS[i].sa});
      chk($sformatf("R8 sel_b vec %0d", i), {30'd0, sel_b_o}, {30'd0, VECS[i].sb});
      chk($sformatf("R11 no code 11 vec %0d", i), {31'd0, (sel_a_o == 2'b11) || (sel_b_o == 2'b11)}, '0);
      chk($sformatf("R3 R4 op_a vec %0d", i), op_a_o, pick(VECS[i].sa, av, wb, ex));
      chk($sformatf("R9 st_data vec %0d", i), st_data_o, fb);
      chk($sformatf("R10 op_b vec %0d", i), op_b_o,
          VECS[i].alu_src ? {{(DW-IW){VECS[i].imm[IW-1]}}, VECS[i].imm} : fb);
    end

    // R2: mid-cycle decode change held off until next edge
    @(negedge clk_i);
    exm_wr_en_i = 1'b0; mwb_wr_en_i = 1'b0;
    dec_a_idx_i = 5'd9; dec_a_val_i = 32'h12340001;
    dec_b_idx_i = 5'd10; dec_b_val_i = 32'h56780001; alu_src_i = 1'b0;
    @(posedge clk_i); #2;
    chk("R2 op_a after edge", op_a_o, 32'h12340001);
    @(negedge clk_i);
    dec_a_val_i = 32'h12340002; dec_b_val_i = 32'h56780002;
    alu_src_i = 1'b1; dec_imm_i = 16'h7777;
    #1;
    chk("R2 op_a held", op_a_o, 32'h12340001);
    chk("R2 op_b held", op_b_o, 32'h56780001);
    @(posedge clk_i); #2;
    chk("R2 op_a updated", op_a_o, 32'h12340002);
    chk("R2 op_b imm updated", op_b_o, 32'h00007777);
    chk("R9 st_data beside imm", st_data_o, 32'h56780002);

    // R7: enable drop alone removes forwarding in same cycle
    @(negedge clk_i);
    alu_src_i = 1'b0;
    exm_wr_en_i = 1'b1; exm_dst_i = 5'd9; exm_alu_res_i = 32'hcafe0009;
    @(posedge clk_i); #2;
    chk("R3 forward on", op_a_o, 32'hcafe0009);
    @(negedge clk_i); exm_wr_en_i = 1'b0;
    @(posedge clk_i); #2;
    chk("R7 forward off", op_a_o, 32'h12340002);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule